// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block decides whether an address arriving from the PCI side lands in one of three inbound memory windows. If it does, the block returns the host address for it. Each window is set up by writing one 32-bit word. The upper twelve bits of that word give the window's starting address in 1 MB units. A four-bit code below them picks a power-of-two size, from 1 MB up to 2 GB. Codes above the 2 GB step switch the window off.

A lookup is presented as an address with a valid strobe. One clock later the block reports a hit or a miss, the number of the window that matched, and the translated address. Every window maps onto host address zero, so the translated address is simply the offset of the incoming address inside its window. The three windows are compared in parallel. When several windows match, the lowest-numbered window wins. Window numbers 0, 1 and 2 follow the order of the three consecutive configuration words the block stands for.

Top module: `inbound_win_dec`

## Requirements
- R1: After reset, every window holds size code 15 (disabled) and base 0. Every response output is 0 until the first lookup, and a lookup made before any write misses.
- R2: When `cfg_we` is high with `cfg_idx` equal to 0, 1 or 2, the chosen window stores `cfg_wdata[31:20]` as its base and `cfg_wdata[19:16]` as its size code, and `cfg_wdata[15:0]` is discarded. A write with `cfg_idx` = 3 changes no window.
- R3: A size code c from 0 to 11 gives a window of 2^(20+c) bytes: code 0 is 1 MB and code 11 is 2 GB.
- R4: An address hits a window when its bits 31 down to 20+c equal the same bits of the base. Base bits below 20+c take no part in the compare.
- R5: On a hit, `rsp_host_addr` equals the lookup address with bits 31 down to 20+c cleared, that is, its offset inside the window.
- R6: Size codes 12 to 15 disable the window, so no address ever hits it.
- R7: When more than one window hits, `rsp_win` reports the lowest-numbered one, and the offset is taken from that window.
- R8: An address that hits no window gives `rsp_miss` = 1, `rsp_hit` = 0, `rsp_win` = 0 and `rsp_host_addr` = 0.
- R9: The response to a lookup appears on the clock edge that samples `lk_valid`, and lookups can be issued every cycle. A lookup issued in the same cycle as a write sees the window settings from before that write.
- R10: `rsp_valid` is high only in the cycle after a lookup. While it is high, exactly one of `rsp_hit` and `rsp_miss` is set, and both are 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Window number to write |
| cfg_wdata | input | 32 | Register word: base in bits 31:20, size code in bits 19:16 |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | PCI-side address to decode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Address falls in a window |
| rsp_miss | output | 1 | Address falls in no window |
| rsp_win | output | 2 | Number of the winning window |
| rsp_host_addr | output | 32 | Translated host address (offset within window) |

## Verification
The size sweep probes each of the twelve valid codes at the last byte inside the window and at the first byte past it. This separates an off-by-one in the mask from a correct one. A base written with its low bits set and unaligned bits above bit 20 shows that the dropped and don't-care bits really are ignored. Overlapping windows are added one at a time to expose the priority order. Out-of-range codes and an out-of-range index show that disabled or absent windows never match. A write paired with a lookup in the same cycle, followed by back-to-back lookups, pins down the one-cycle timing and which settings a lookup observes.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
    // Address and register field geometry
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 20;   // smallest window is 2**BASE_LSB bytes
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 11;   // largest valid size code
    localparam int BASE_W   = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;
endpackage

// File: rtl/iwin_size_dec.sv
// Turns a logarithmic size code into an offset mask and an enable.
module iwin_size_dec #(
    parameter int ADDR_W   = iwin_pkg::ADDR_W,
    parameter int BASE_LSB = iwin_pkg::BASE_LSB,
    parameter int CODE_W   = iwin_pkg::CODE_W,
    parameter int MAX_CODE = iwin_pkg::MAX_CODE
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] off_mask,
    output logic              en
);
    always_comb begin
        en = (int'(code) <= MAX_CODE);
        // thermometer: bit i is offset when i < BASE_LSB + code
        for (int i = 0; i < ADDR_W; i++) begin
            off_mask[i] = (i < (BASE_LSB + int'(code)));
        end
    end
endmodule

// File: rtl/iwin_match.sv
// Compares one address against one window and extracts the offset.
module iwin_match #(
    parameter int ADDR_W   = iwin_pkg::ADDR_W,
    parameter int BASE_LSB = iwin_pkg::BASE_LSB,
    localparam int BASE_W  = ADDR_W - BASE_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] off_mask,
    input  logic              en,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        base_full = {base, {BASE_LSB{1'b0}}};
        hit       = en && ((addr & ~off_mask) == (base_full & ~off_mask));
        offset    = addr & off_mask;
    end
endmodule

// File: rtl/iwin_prio.sv
// Fixed priority select: lowest-numbered hitting window wins.
module iwin_prio #(
    parameter int NUM_WIN = 3,
    parameter int ADDR_W  = iwin_pkg::ADDR_W,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0]             hits,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs,
    output logic                           any,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-1:0]              off
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        off = '0;
        // scan downward so the lowest index is applied last
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                off = offs[i];
            end
        end
    end
endmodule

// File: rtl/inbound_win_dec.sv
module inbound_win_dec #(
    parameter int NUM_WIN  = 3,
    parameter int RST_CODE = 15,
    parameter int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [iwin_pkg::ADDR_W-1:0] cfg_wdata,
    input  logic                        lk_valid,
    input  logic [iwin_pkg::ADDR_W-1:0] lk_addr,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic                        rsp_miss,
    output logic [IDX_W-1:0]            rsp_win,
    output logic [iwin_pkg::ADDR_W-1:0] rsp_host_addr
);
    import iwin_pkg::*;

    localparam int CODE_LSB = BASE_LSB - CODE_W;

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] cfg;
        logic                   rsp_valid;
        logic                   rsp_hit;
        logic                   rsp_miss;
        logic [IDX_W-1:0]       rsp_win;
        logic [ADDR_W-1:0]      rsp_addr;
    } state_t;

    function automatic state_t rst_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            s.cfg[i].code = CODE_W'(RST_CODE);
        end
        return s;
    endfunction

    state_t st_d, st_q;

    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_off;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel_idx;
    logic [ADDR_W-1:0]              sel_off;

    // register bits below the size code carry nothing
    logic unused_wdata_low;
    assign unused_wdata_low = ^cfg_wdata[CODE_LSB-1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [ADDR_W-1:0] mask;
        logic              en;

        iwin_size_dec #(
            .ADDR_W  (ADDR_W),
            .BASE_LSB(BASE_LSB),
            .CODE_W  (CODE_W),
            .MAX_CODE(MAX_CODE)
        ) u_size (
            .code    (st_q.cfg[g].code),
            .off_mask(mask),
            .en      (en)
        );

        iwin_match #(
            .ADDR_W  (ADDR_W),
            .BASE_LSB(BASE_LSB)
        ) u_match (
            .addr    (lk_addr),
            .base    (st_q.cfg[g].base),
            .off_mask(mask),
            .en      (en),
            .hit     (win_hit[g]),
            .offset  (win_off[g])
        );
    end

    iwin_prio #(
        .NUM_WIN(NUM_WIN),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_prio (
        .hits(win_hit),
        .offs(win_off),
        .any (any_hit),
        .idx (sel_idx),
        .off (sel_off)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_idx) < NUM_WIN)) begin
            st_d.cfg[cfg_idx].base = cfg_wdata[ADDR_W-1:BASE_LSB];
            st_d.cfg[cfg_idx].code = cfg_wdata[BASE_LSB-1:CODE_LSB];
        end
        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = lk_valid && any_hit;
        st_d.rsp_miss  = lk_valid && !any_hit;
        st_d.rsp_win   = (lk_valid && any_hit) ? sel_idx : '0;
        st_d.rsp_addr  = (lk_valid && any_hit) ? sel_off : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= rst_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_hit       = st_q.rsp_hit;
    assign rsp_miss      = st_q.rsp_miss;
    assign rsp_win       = st_q.rsp_win;
    assign rsp_host_addr = st_q.rsp_addr;
endmodule

// File: rtl/iwin_chk.sv
module iwin_chk #(
    parameter int NUM_WIN = 3,
    parameter int IDX_W   = 2,
    parameter int ADDR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [IDX_W-1:0]  rsp_win,
    input logic [ADDR_W-1:0] rsp_host_addr
);
    p_lat_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_lat_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_one_of_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_win == '0 && rsp_host_addr == '0));

    p_win_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (int'(rsp_win) < NUM_WIN));

    // offset keeps only bits of the address that was looked up
    p_offset_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ((rsp_host_addr & ~$past(lk_addr)) == '0));

    // every window spans at least 1 MB, so the low 20 bits pass through
    p_low_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_host_addr[19:0] == $past(lk_addr[19:0])));
endmodule

bind inbound_win_dec iwin_chk #(
    .NUM_WIN(NUM_WIN),
    .IDX_W  (IDX_W),
    .ADDR_W (iwin_pkg::ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_addr      (lk_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_win      (rsp_win),
    .rsp_host_addr(rsp_host_addr)
);

// File: tb/sim_inbound_win_dec.sv
`timescale 1ns/1ps
module sim_inbound_win_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_host_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    inbound_win_dec u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_host_addr(rsp_host_addr)
    );

    // Compare the whole response against an expectation
    task automatic check_rsp(input bit ev, input bit eh, input int ew,
                             input logic [31:0] ea, input string tag);
        bit em;
        em = ev && !eh;
        n_chk++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_miss !== em ||
            rsp_win !== 2'(ew) || rsp_host_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: got v=%0b h=%0b m=%0b w=%0d a=%h, expected v=%0b h=%0b m=%0b w=%0d a=%h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_host_addr,
                     ev, eh, em, ew, ea);
        end
    endtask

    task automatic write_win(input int idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input bit eh, input int ew,
                          input logic [31:0] ea, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check_rsp(1'b1, eh, ew, ea, tag);
    endtask

    task automatic t_reset();
        check_rsp(1'b0, 1'b0, 0, 32'h0, "R1 idle outputs after reset");
        lookup(32'h0000_0000, 1'b0, 0, 32'h0, "R1 lookup misses before any write");
        lookup(32'h7FFF_FFFF, 1'b0, 0, 32'h0, "R8 miss outputs zeroed");
    endtask

    task automatic t_sizes();
        for (int c = 0; c <= 11; c++) begin
            logic [31:0] last;
            last = 32'((64'd1 << (20 + c)) - 1);
            write_win(0, 32'(c) << 16);
            lookup(last, 1'b1, 0, last, $sformatf("R3 code %0d last byte hits", c));
            lookup(last + 32'd1, 1'b0, 0, 32'h0, $sformatf("R3 code %0d end+1 misses", c));
        end
    endtask

    task automatic t_invalid();
        for (int c = 12; c <= 15; c++) begin
            write_win(0, 32'(c) << 16);
            lookup(32'h0000_0000, 1'b0, 0, 32'h0, $sformatf("R6 code %0d disabled", c));
        end
    endtask

    task automatic t_base();
        // low 16 bits set: must be discarded (R2)
        write_win(1, 32'h4010_ABCD);
        lookup(32'h4010_0123, 1'b1, 1, 32'h0000_0123, "R2 R5 1MB window at 0x40100000");
        lookup(32'h4000_0123, 1'b0, 0, 32'h0, "R4 below window misses");
        lookup(32'h4020_0000, 1'b0, 0, 32'h0, "R4 above window misses");
    endtask

    task automatic t_align();
        // 4 MB window, base bits 21:20 set and ignored
        write_win(1, 32'h4032_0000);
        lookup(32'h4000_0010, 1'b1, 1, 32'h0000_0010, "R4 unaligned base bits ignored");
        lookup(32'h403F_FFFF, 1'b1, 1, 32'h003F_FFFF, "R5 offset at top of 4MB window");
        lookup(32'h4040_0000, 1'b0, 0, 32'h0, "R4 past 4MB window misses");
    endtask

    task automatic t_prio();
        write_win(2, 32'h000B_0000); // 2 GB at 0
        lookup(32'h4000_0050, 1'b1, 1, 32'h0000_0050, "R7 window 1 beats window 2");
        lookup(32'h1234_5678, 1'b1, 2, 32'h1234_5678, "R7 only window 2 hits");
        write_win(0, 32'h4000_0000); // 1 MB at 0x40000000
        lookup(32'h4000_0050, 1'b1, 0, 32'h0000_0050, "R7 window 0 beats windows 1 and 2");
        lookup(32'h4010_0000, 1'b1, 1, 32'h0010_0000, "R7 window 1 beats window 2");
        lookup(32'h9000_0000, 1'b0, 0, 32'h0, "R8 address in no window");
    endtask

    task automatic t_bad_idx();
        write_win(3, 32'h9000_0000);
        lookup(32'h9000_0000, 1'b0, 0, 32'h0, "R2 index 3 write ignored");
        lookup(32'h4000_0050, 1'b1, 0, 32'h0000_0050, "R2 window 0 unchanged by index 3");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 32'h9000_0000;
        lk_valid = 1'b1; lk_addr = 32'h9000_0005;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        check_rsp(1'b1, 1'b0, 0, 32'h0, "R9 same-cycle lookup sees old settings");
        lookup(32'h9000_0005, 1'b1, 0, 32'h0000_0005, "R9 next lookup sees new settings");
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h9000_0001;
        @(negedge clk);
        check_rsp(1'b1, 1'b1, 0, 32'h0000_0001, "R9 first of back-to-back");
        lk_addr = 32'h0000_0002;
        @(negedge clk);
        check_rsp(1'b1, 1'b1, 2, 32'h0000_0002, "R9 second of back-to-back");
        lk_valid = 1'b0;
        @(negedge clk);
        check_rsp(1'b0, 1'b0, 0, 32'h0, "R10 response drops after lookups stop");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_invalid();
        t_base();
        t_align();
        t_prio();
        t_bad_idx();
        t_same_cycle();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout after %0d cycles, expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule